// File: doc/BRIEF.md
# Call-Progress Cadence Classifier

This block sorts supervisory telephone tones by their rhythm. Its input is a one-bit energy envelope from an analog energy detector. The envelope is high while tone energy is present on the line. Time is measured in ticks of a millisecond timebase. The block does not look at frequency. It looks only at how long each burst of energy lasts and how long each gap lasts.

The block first removes short pulses and gaps from the envelope. It then measures every on period and every off period in ticks. Each period is tested against tolerance windows around the nominal on and off times of three cadences: line busy, reorder and audible ringing. A periodic class is reported only after two full on/off cycles of the same class have matched in a row. Unbroken energy lasting long enough is reported as a continuous (dial) tone. A long silence, or any period that fits no window, sends the output back to unknown. Speech and signalling digits also toggle the envelope, so they end up reported as unknown.

The class appears on a three-bit code, together with a strobe that marks each change of the code. An envelope change that is accepted on tick cycle T reaches the class output at the second clock edge after T.

Top module: `cadence_classifier`

## Requirements
- R1: While reset is asserted and just after it is released, `class_code` is 0 (unknown) and `class_stb` is 0. The class codes are: 0 unknown, 1 continuous, 2 busy, 3 reorder, 4 ringing.
- R2: An envelope level that differs from the filtered level for fewer than 20 consecutive ticks has no effect on timing or class. A level that differs for 20 consecutive ticks is accepted on its 20th tick.
- R3: A busy cycle has an on period of 425 to 575 ticks and an off period of 425 to 575 ticks, bounds inclusive. A length of 424 or 576 ticks does not match busy.
- R4: A reorder cycle has an on period of 213 to 287 ticks and an off period of 213 to 287 ticks, bounds inclusive.
- R5: A ringing cycle has an on period of 1700 to 2300 ticks and an off period of 3400 to 4600 ticks, bounds inclusive.
- R6: Busy, reorder or ringing is reported when the off period of the second consecutive matching cycle of that class ends, that is, at the next accepted rise of energy. One matching cycle alone leaves the code at unknown. A matching cycle of a different class restarts the count and sets the code to unknown. Further matching cycles of the same class keep the code unchanged.
- R7: Continuous (1) is reported on the 3000th tick of unbroken accepted energy, while the energy is still present.
- R8: On the 6000th tick of accepted silence, the code returns to unknown.
- R9: An on period that fits no on window, or an off period that fits no off window or does not pair with the class of the on period before it, sets the code to unknown as soon as that period ends.
- R10: `class_stb` is high for exactly the cycles in which `class_code` shows a value different from the one it showed in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released internally on the clock |
| ms_tick | input | 1 | One-cycle pulse per millisecond; all timing counts these pulses |
| env_in | input | 1 | Energy envelope, high while tone energy is present |
| class_code | output | 3 | Current class: 0 unknown, 1 continuous, 2 busy, 3 reorder, 4 ringing |
| class_stb | output | 1 | High in the cycle in which `class_code` takes a new value |

## Verification
Suppose the glitch filter has a wrong count. The accepted edges then shift. A pulse just under 20 ticks would split a period, and the code would fall to unknown within about 20 ticks. Suppose the period counter is wrong. A length at a window edge (424, 425, 575, 576) would then be classed wrongly, and the error would show as soon as that period ends. Suppose the cycle-pairing state is wrong. A periodic class would then be reported one full cycle early or late, which is hundreds of ticks. The bench compares the code and the strobe against its own model on every clock, so any of these faults shows at the ports within one clock of the first wrong decision.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [2:0] {
    CLS_UNKNOWN = 3'd0,
    CLS_CONT    = 3'd1,
    CLS_BUSY    = 3'd2,
    CLS_REORDER = 3'd3,
    CLS_RING    = 3'd4
  } cls_e;

  // number of periodic cadences tested by window
  localparam int unsigned NUM_PERIODIC = 3;

  // class code assigned to periodic cadence index k
  function automatic cls_e periodic_class(input int unsigned k);
    case (k)
      0:       return CLS_BUSY;
      1:       return CLS_REORDER;
      default: return CLS_RING;
    endcase
  endfunction

endpackage

// File: rtl/cpc_deglitch.sv
module cpc_deglitch #(
  parameter int unsigned MIN_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic env_raw,
  output logic env_filt
);

  localparam int unsigned CW = $clog2(MIN_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_MS - 1);

  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (env_raw == filt_q) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      if (cnt_q == LAST) begin
        filt_d = env_raw;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign env_filt = filt_q;

  // R2: the filtered level can only move on a tick
  a_r2_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> $stable(filt_q));

  // R2: an input that agrees with the filtered level never moves it
  a_r2_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (env_raw == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/cpc_period_meter.sv
module cpc_period_meter #(
  parameter int unsigned CONT_MS = 3000,
  parameter int unsigned SIL_MS  = 6000,
  parameter int unsigned LEN_W   = $clog2(SIL_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             env_filt,
  output logic             on_end,
  output logic             off_end,
  output logic [LEN_W-1:0] per_len,
  output logic             cont_hit,
  output logic             silence_hit
);

  localparam logic [LEN_W-1:0] RUN_CAP  = LEN_W'(SIL_MS);
  localparam logic [LEN_W-1:0] CONT_PRE = LEN_W'(CONT_MS - 1);
  localparam logic [LEN_W-1:0] SIL_PRE  = LEN_W'(SIL_MS - 1);

  logic             lvl_q, lvl_d;
  logic [LEN_W-1:0] run_q, run_d;
  logic             edge_seen;

  assign edge_seen   = (env_filt != lvl_q);
  assign on_end      = edge_seen & lvl_q;
  assign off_end     = edge_seen & ~lvl_q;
  assign per_len     = run_q;
  assign cont_hit    = ~edge_seen & lvl_q & ms_tick & (run_q == CONT_PRE);
  assign silence_hit = ~edge_seen & ~lvl_q & ms_tick & (run_q == SIL_PRE);

  always_comb begin
    lvl_d = env_filt;
    run_d = run_q;
    if (edge_seen) begin
      run_d = '0;
    end else if (ms_tick && (run_q != RUN_CAP)) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

  // R8: the run length advances only on ticks while the level holds
  a_r8_run_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ms_tick && env_filt == lvl_q) |=> $stable(run_q));

endmodule

// File: rtl/cpc_cadence_match.sv
module cpc_cadence_match
  import cpc_pkg::*;
#(
  parameter int unsigned LEN_W      = 13,
  parameter int unsigned TOL_PCT    = 15,
  parameter int unsigned CYC_REQ    = 2,
  parameter int unsigned BUSY_ON    = 500,
  parameter int unsigned BUSY_OFF   = 500,
  parameter int unsigned REORD_ON   = 250,
  parameter int unsigned REORD_OFF  = 250,
  parameter int unsigned RING_ON    = 2000,
  parameter int unsigned RING_OFF   = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_end,
  input  logic             off_end,
  input  logic [LEN_W-1:0] per_len,
  input  logic             cont_hit,
  input  logic             silence_hit,
  output logic [2:0]       class_code,
  output logic             class_stb
);

  localparam int unsigned CNT_W = $clog2(CYC_REQ + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CYC_REQ);

  logic [NUM_PERIODIC-1:0] on_hit, off_hit;

  // one pair of inclusive windows per periodic cadence
  for (genvar k = 0; k < NUM_PERIODIC; k++) begin : g_win
    localparam int unsigned NOM_ON  = (k == 0) ? BUSY_ON  : (k == 1) ? REORD_ON  : RING_ON;
    localparam int unsigned NOM_OFF = (k == 0) ? BUSY_OFF : (k == 1) ? REORD_OFF : RING_OFF;
    localparam int unsigned ON_LO   = (NOM_ON  * (100 - TOL_PCT) + 99) / 100;
    localparam int unsigned ON_HI   = (NOM_ON  * (100 + TOL_PCT)) / 100;
    localparam int unsigned OFF_LO  = (NOM_OFF * (100 - TOL_PCT) + 99) / 100;
    localparam int unsigned OFF_HI  = (NOM_OFF * (100 + TOL_PCT)) / 100;
    assign on_hit[k]  = (per_len >= LEN_W'(ON_LO))  && (per_len <= LEN_W'(ON_HI));
    assign off_hit[k] = (per_len >= LEN_W'(OFF_LO)) && (per_len <= LEN_W'(OFF_HI));
  end

  cls_e on_match, off_match;

  always_comb begin
    on_match  = CLS_UNKNOWN;
    off_match = CLS_UNKNOWN;
    for (int k = NUM_PERIODIC - 1; k >= 0; k--) begin
      if (on_hit[k])  on_match  = periodic_class(k);
      if (off_hit[k]) off_match = periodic_class(k);
    end
  end

  cls_e             cls_q, cls_d;
  cls_e             on_cls_q, on_cls_d;
  cls_e             run_cls_q, run_cls_d;
  logic [CNT_W-1:0] run_cnt_q, run_cnt_d;
  logic             stb_q, stb_d;

  always_comb begin
    cls_d     = cls_q;
    on_cls_d  = on_cls_q;
    run_cls_d = run_cls_q;
    run_cnt_d = run_cnt_q;
    if (silence_hit) begin
      cls_d     = CLS_UNKNOWN;
      on_cls_d  = CLS_UNKNOWN;
      run_cnt_d = '0;
    end else if (cont_hit) begin
      cls_d     = CLS_CONT;
      run_cnt_d = '0;
    end else if (on_end) begin
      on_cls_d = on_match;
      if (on_match == CLS_UNKNOWN) begin
        cls_d     = CLS_UNKNOWN;
        run_cnt_d = '0;
      end
    end else if (off_end) begin
      on_cls_d = CLS_UNKNOWN;
      if ((off_match != CLS_UNKNOWN) && (off_match == on_cls_q)) begin
        if (run_cls_q == off_match) begin
          if (run_cnt_q != CNT_FULL) run_cnt_d = run_cnt_q + 1'b1;
        end else begin
          run_cls_d = off_match;
          run_cnt_d = CNT_W'(1);
        end
        cls_d = (run_cnt_d >= CNT_FULL) ? off_match : CLS_UNKNOWN;
      end else begin
        cls_d     = CLS_UNKNOWN;
        run_cnt_d = '0;
      end
    end
    stb_d = (cls_d != cls_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q     <= CLS_UNKNOWN;
      on_cls_q  <= CLS_UNKNOWN;
      run_cls_q <= CLS_UNKNOWN;
      run_cnt_q <= '0;
      stb_q     <= 1'b0;
    end else begin
      cls_q     <= cls_d;
      on_cls_q  <= on_cls_d;
      run_cls_q <= run_cls_d;
      run_cnt_q <= run_cnt_d;
      stb_q     <= stb_d;
    end
  end

  assign class_code = cls_q;
  assign class_stb  = stb_q;

  // R10: strobe marks a change of the code, and only a change
  a_r10_stb_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (cls_q != $past(cls_q)));
  a_r10_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(cls_q));

  // R6: a periodic class appears only right after an off period closed
  a_r6_periodic_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_q != $past(cls_q)) &&
     (cls_q == CLS_BUSY || cls_q == CLS_REORDER || cls_q == CLS_RING))
    |-> $past(off_end));

  // R7: continuous appears only right after the long-energy mark
  a_r7_cont_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_q == CLS_CONT) && ($past(cls_q) != CLS_CONT)) |-> $past(cont_hit));

endmodule

// File: rtl/cadence_classifier.sv
module cadence_classifier #(
  parameter int unsigned MIN_MS    = 20,
  parameter int unsigned CONT_MS   = 3000,
  parameter int unsigned SIL_MS    = 6000,
  parameter int unsigned TOL_PCT   = 15,
  parameter int unsigned CYC_REQ   = 2,
  parameter int unsigned BUSY_ON   = 500,
  parameter int unsigned BUSY_OFF  = 500,
  parameter int unsigned REORD_ON  = 250,
  parameter int unsigned REORD_OFF = 250,
  parameter int unsigned RING_ON   = 2000,
  parameter int unsigned RING_OFF  = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       env_in,
  output logic [2:0] class_code,
  output logic       class_stb
);

  localparam int unsigned LEN_W = $clog2(SIL_MS + 1);

  // reset: asserted at once, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             env_filt;
  logic             on_end, off_end, cont_hit, silence_hit;
  logic [LEN_W-1:0] per_len;

  cpc_deglitch #(.MIN_MS(MIN_MS)) u_deglitch (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .ms_tick  (ms_tick),
    .env_raw  (env_in),
    .env_filt (env_filt)
  );

  cpc_period_meter #(.CONT_MS(CONT_MS), .SIL_MS(SIL_MS), .LEN_W(LEN_W)) u_meter (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .ms_tick     (ms_tick),
    .env_filt    (env_filt),
    .on_end      (on_end),
    .off_end     (off_end),
    .per_len     (per_len),
    .cont_hit    (cont_hit),
    .silence_hit (silence_hit)
  );

  cpc_cadence_match #(
    .LEN_W(LEN_W), .TOL_PCT(TOL_PCT), .CYC_REQ(CYC_REQ),
    .BUSY_ON(BUSY_ON), .BUSY_OFF(BUSY_OFF),
    .REORD_ON(REORD_ON), .REORD_OFF(REORD_OFF),
    .RING_ON(RING_ON), .RING_OFF(RING_OFF)
  ) u_match (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .on_end      (on_end),
    .off_end     (off_end),
    .per_len     (per_len),
    .cont_hit    (cont_hit),
    .silence_hit (silence_hit),
    .class_code  (class_code),
    .class_stb   (class_stb)
  );

  // R1: nothing is reported while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_s2_q |=> (class_code == 3'd0 && !class_stb));

endmodule

// File: tb/cadence_classifier_bench.sv
module cadence_classifier_bench;

  logic       clk;
  logic       rst_n;
  logic       ms_tick;
  logic       env_in;
  logic [2:0] class_code;
  logic       class_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  cadence_classifier u_cadence_classifier (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .env_in     (env_in),
    .class_code (class_code),
    .class_stb  (class_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // tick on every second clock
  initial begin
    ms_tick = 1'b0;
    forever begin
      @(negedge clk);
      ms_tick = ~ms_tick;
    end
  end

  // ---------------- behavioural reference model ----------------
  function automatic int in_win(input int len, input int nom);
    return ((len * 100 >= nom * 85) && (len * 100 <= nom * 115)) ? 1 : 0;
  endfunction
  function automatic int on_kind(input int len);
    if (in_win(len, 500))  return 2;
    if (in_win(len, 250))  return 3;
    if (in_win(len, 2000)) return 4;
    return 0;
  endfunction
  function automatic int off_kind(input int len);
    if (in_win(len, 500))  return 2;
    if (in_win(len, 250))  return 3;
    if (in_win(len, 4000)) return 4;
    return 0;
  endfunction

  int m_rel, f_lvl, f_cnt, p_lvl, p_run;
  int m_cls, m_stb, m_on, m_rc, m_rn;

  always @(posedge clk) begin
    int ed, nc, k;
    if (!rst_n || m_rel < 2) begin
      if (!rst_n) m_rel = 0; else m_rel = m_rel + 1;
      f_lvl = 0; f_cnt = 0; p_lvl = 0; p_run = 0;
      m_cls = 0; m_stb = 0; m_on = 0; m_rc = 0; m_rn = 0;
    end else begin
      ed = (f_lvl != p_lvl) ? 1 : 0;
      nc = m_cls;
      if (!ed && p_lvl == 0 && ms_tick && p_run == 5999) begin
        nc = 0; m_on = 0; m_rn = 0;
      end else if (!ed && p_lvl == 1 && ms_tick && p_run == 2999) begin
        nc = 1; m_rn = 0;
      end else if (ed && p_lvl == 1) begin
        m_on = on_kind(p_run);
        if (m_on == 0) begin nc = 0; m_rn = 0; end
      end else if (ed && p_lvl == 0) begin
        k = off_kind(p_run);
        if (k != 0 && k == m_on) begin
          if (m_rc == k) begin if (m_rn < 2) m_rn = m_rn + 1; end
          else begin m_rc = k; m_rn = 1; end
          nc = (m_rn >= 2) ? k : 0;
        end else begin
          nc = 0; m_rn = 0;
        end
        m_on = 0;
      end
      m_stb = (nc != m_cls) ? 1 : 0;
      m_cls = nc;
      if (ed) p_run = 0;
      else if (ms_tick && p_run < 6000) p_run = p_run + 1;
      p_lvl = f_lvl;
      if (env_in == f_lvl[0]) f_cnt = 0;
      else if (ms_tick) begin
        if (f_cnt == 19) begin f_lvl = env_in; f_cnt = 0; end
        else f_cnt = f_cnt + 1;
      end
    end
  end

  // per-clock comparison, away from the active edge
  logic [2:0] prev_code = 3'd0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (class_code !== 3'(m_cls) || class_stb !== 1'(m_stb)) begin
        errors++;
        $display("FAIL %s model: code=%0d stb=%0d expected code=%0d stb=%0d at %0t",
                 cur_req, class_code, class_stb, m_cls, m_stb, $time);
      end
      checks++;
      if (class_stb !== (class_code != prev_code)) begin
        errors++;
        $display("FAIL R10 strobe: stb=%0d expected %0d at %0t",
                 class_stb, (class_code != prev_code), $time);
      end
      prev_code = class_code;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input bit lvl, input int ms);
    env_in = lvl;
    repeat (ms * 2) @(negedge clk);
  endtask

  task automatic chk(input string req, input int exp);
    checks++;
    if (class_code !== 3'(exp)) begin
      errors++;
      $display("FAIL %s: class_code=%0d expected %0d at %0t", req, class_code, exp, $time);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    env_in = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (class_code !== 3'd0 || class_stb !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: code=%0d stb=%0d expected 0 0", class_code, class_stb);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 0);

    // busy: one cycle is not enough, two are
    cur_req = "R6";
    hold(1, 500); hold(0, 500); hold(1, 30);
    chk("R6 single cycle", 0);
    hold(1, 470); hold(0, 500); hold(1, 30);
    chk("R3 busy declared", 2);
    hold(1, 470);
    cur_req = "R8";
    hold(0, 5900);
    chk("R8 before silence limit", 2);
    hold(0, 200);
    chk("R8 silence", 0);

    // reorder, then a busy cycle breaks it
    cur_req = "R4";
    hold(1, 250); hold(0, 250); hold(1, 250); hold(0, 250); hold(1, 30);
    chk("R4 reorder declared", 3);
    hold(1, 220);
    cur_req = "R6";
    hold(0, 250); hold(1, 500); hold(0, 30);
    chk("R6 holds until cycle closes", 3);
    hold(0, 470); hold(1, 30);
    chk("R6 other class restarts", 0);
    hold(1, 470);

    // busy window edges 425 and 575
    cur_req = "R3";
    hold(0, 425); hold(1, 30);
    chk("R3 off 425 accepted", 2);
    hold(1, 545); hold(0, 575); hold(1, 30);
    chk("R3 575 accepted", 2);
    hold(1, 70);
    cur_req = "R9";
    hold(0, 30);
    chk("R9 short on period", 0);
    hold(0, 470);

    // 576 and 424 rejected, then recovery
    cur_req = "R3";
    hold(1, 576); hold(0, 500); hold(1, 30);
    chk("R3 on 576 rejected", 0);
    hold(1, 470); hold(0, 424); hold(1, 30);
    chk("R3 off 424 rejected", 0);
    hold(1, 470); hold(0, 500); hold(1, 500); hold(0, 500); hold(1, 30);
    chk("R6 recovery after two cycles", 2);
    hold(1, 470);
    hold(0, 7000);
    chk("R8 silence again", 0);

    // ringing
    cur_req = "R5";
    hold(1, 2000); hold(0, 4000); hold(1, 2000); hold(0, 4000); hold(1, 30);
    chk("R5 ringing declared", 4);
    hold(1, 20);
    cur_req = "R9";
    hold(0, 30);
    chk("R9 on 50 rejected", 0);

    // continuous
    cur_req = "R7";
    hold(0, 6970); hold(1, 2900);
    chk("R7 before 3000", 0);
    hold(1, 200);
    chk("R7 continuous", 1);
    hold(1, 400);
    cur_req = "R9";
    hold(0, 30);
    chk("R9 long on period ends continuous", 0);
    hold(0, 470);

    // glitches of 19 ticks are invisible
    cur_req = "R2";
    for (int c = 0; c < 2; c++) begin
      hold(1, 240); hold(0, 19); hold(1, 241);
      hold(0, 240); hold(1, 19); hold(0, 241);
    end
    hold(1, 30);
    chk("R2 19-tick glitches ignored", 2);
    hold(1, 210);
    // a 20-tick gap is accepted and splits the burst
    hold(0, 20); hold(1, 30);
    chk("R2 20-tick gap accepted", 0);
    hold(1, 210); hold(0, 100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule